// File: doc/BRIEF.md
# Instruction-Driven Acquisition Sequencer

This block runs a short program of acquisition steps against an external analog-to-digital converter. Software writes up to eight instruction words, along with an acquisition length, a pair of signed compare limits and a request threshold. It then raises a run control. For each instruction the sequencer fetches and decodes the word and holds a timed acquisition window. It then issues a one-cycle start to the converter and waits for the converter's done strobe.

A normal instruction yields a two's complement result, either 13 bits wide or 9 bits wide, tagged with its channel number. That word goes into a 32-entry result queue, which software drains through a read port. A compare instruction does not store its result. It checks the result against the low and high limits and raises an interrupt when the value falls outside them. A request line for a DMA engine stays high while the queue holds at least the programmed number of words.

Top module: `acq_sequencer`

## Requirements
- R1: After reset, fill is 0, and irq, dmarq, overflow, busy and conv_start are all 0. The acquisition length is 9 and the request threshold is 16.
- R2: Configuration writes use these addresses. Addresses 0..7 hold instruction words. Address 8 holds the acquisition length in cycles, where 0 acts as 1. Address 9 is the signed low limit and address 10 the signed high limit. Address 11 is the request threshold. A write of any value to address 12 clears the overflow flag.
- R3: Run is a level. Its rising edge, seen while idle, starts at instruction 0. conv_start is high for exactly one cycle, and that cycle comes acquisition length + 3 clock edges after the edge that saw run rise.
- R4: The instruction word has these fields: bits [2:0] channel, bit 3 reduced resolution, bit 4 compare, bit 5 pause, bit 6 last. In full resolution the stored word is {channel, conv_result[12:0]}.
- R5: In reduced resolution only conv_result[8:0] is used. It is sign-extended to 13 bits, so the stored word is {channel, sext(conv_result[8:0])}.
- R6: After an instruction with the last bit set, the next instruction is entry 0. Otherwise the next instruction is the following entry, and entry 7 wraps to 0. After an instruction with the pause bit set, busy drops and the block waits for a new rising edge of run.
- R7: If run is low when the next instruction would be fetched, the block goes idle and busy drops.
- R8: A compare instruction never writes to the queue. It sets irq when the 16-bit sign-extended result is below the low limit or above the high limit. A result within the limits leaves irq at 0.
- R9: irq stays set until a read strobe (rd_en) occurs.
- R10: The queue is first-in first-out and holds 32 words. A result that arrives while the queue is full is dropped and sets overflow. Overflow stays set until the write to address 12.
- R11: dmarq is high exactly when fill is greater than or equal to the request threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| run | input | 1 | Start/stop level |
| conv_start | output | 1 | One-cycle converter start |
| conv_chan | output | 3 | Channel for the converter |
| conv_short | output | 1 | Reduced-resolution request |
| conv_done | input | 1 | Converter done strobe |
| conv_result | input | 13 | Converter result, two's complement |
| rd_en | input | 1 | Queue read strobe; also clears irq |
| rd_data | output | 16 | Word at the queue head |
| fill | output | 6 | Number of words in the queue |
| overflow | output | 1 | Sticky dropped-result flag |
| irq | output | 1 | Limit-violation interrupt |
| dmarq | output | 1 | Fill at or above threshold |
| busy | output | 1 | Sequencer not idle |

## Verification
The hardest state to reach from the ports is a full queue that keeps receiving results, because that is the only state in which words are dropped and overflow is set. The stimulus fills all eight instruction entries with non-pausing, full-resolution work, so the program wraps freely. It leaves run high until fill reaches 32, then lets several more instructions complete. Draining the queue afterwards checks the dmarq threshold crossing on the way down. The acquisition window is measured by counting clock edges from the run edge to conv_start, for two different lengths.

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter int NINS      = 8,
  parameter int DEPTH     = 32,
  parameter int ACQ_RESET = 9,
  parameter int THR_RESET = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_addr,
  input  logic [15:0] cfg_wdata,
  input  logic        run,
  output logic        conv_start,
  output logic [2:0]  conv_chan,
  output logic        conv_short,
  input  logic        conv_done,
  input  logic [12:0] conv_result,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  output logic [5:0]  fill,
  output logic        overflow,
  output logic        irq,
  output logic        dmarq,
  output logic        busy
);
  localparam int PW = $clog2(NINS);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DECODE, S_ACQ, S_ISSUE, S_WAIT} st_t;

  st_t                st;
  logic [6:0]         imem [NINS];
  logic [6:0]         ir;
  logic [PW-1:0]      pc;
  logic [15:0]        acq_len, tmr;
  logic signed [15:0] lo_lim, hi_lim;
  logic [CW-1:0]      thresh, cnt;
  logic [AW-1:0]      wp, rp;
  logic [15:0]        mem [DEPTH];
  logic               run_q;

  wire        done_ev = (st == S_WAIT) && conv_done;
  wire [12:0] res13   = ir[3] ? {{4{conv_result[8]}}, conv_result[8:0]} : conv_result;
  wire signed [15:0] res16 = {{3{res13[12]}}, res13};
  wire        outside = (res16 < lo_lim) || (res16 > hi_lim);
  wire        full    = (cnt == CW'(DEPTH));
  wire        push    = done_ev && !ir[4] && !full;
  wire        drop    = done_ev && !ir[4] && full;
  wire        pop     = rd_en && (cnt != '0);

  assign conv_start = (st == S_ISSUE);
  assign conv_chan  = ir[2:0];
  assign conv_short = ir[3];
  assign rd_data    = mem[rp];
  assign fill       = 6'(cnt);
  assign dmarq      = (cnt >= thresh);
  assign busy       = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acq_len <= 16'(ACQ_RESET);
      lo_lim  <= '0;
      hi_lim  <= '0;
      thresh  <= CW'(THR_RESET);
    end else if (cfg_we) begin
      if (cfg_addr < 4'(NINS)) imem[cfg_addr[PW-1:0]] <= cfg_wdata[6:0];
      case (cfg_addr)
        4'd8:    acq_len <= cfg_wdata;
        4'd9:    lo_lim  <= cfg_wdata;
        4'd10:   hi_lim  <= cfg_wdata;
        4'd11:   thresh  <= cfg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pc    <= '0;
      ir    <= '0;
      tmr   <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run;
      case (st)
        S_IDLE:   if (run && !run_q) begin pc <= '0; st <= S_FETCH; end
        S_FETCH:  if (!run) st <= S_IDLE;
                  else begin ir <= imem[pc]; st <= S_DECODE; end
        S_DECODE: begin tmr <= (acq_len == 0) ? 16'd1 : acq_len; st <= S_ACQ; end
        S_ACQ:    if (tmr <= 16'd1) st <= S_ISSUE; else tmr <= tmr - 16'd1;
        S_ISSUE:  st <= S_WAIT;
        S_WAIT:   if (conv_done) begin
                    pc <= ir[6] ? '0 : pc + 1'b1;
                    st <= ir[5] ? S_IDLE : S_FETCH;
                  end
        default:  st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {ir[2:0], res13};
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      if (drop) overflow <= 1'b1;
      else if (cfg_we && cfg_addr == 4'd12) overflow <= 1'b0;
      if (done_ev && ir[4] && outside) irq <= 1'b1;
      else if (rd_en) irq <= 1'b0;
    end
  end

  assert_one_cycle_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_fill_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= 6'(DEPTH));
  assert_drop_keeps_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !rd_en) |=> (fill == 6'(DEPTH) && overflow));
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st != S_WAIT) |=> !irq);
  assert_compare_no_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && ir[4] && !rd_en) |=> $stable(fill));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && ir[6] && !ir[5]) |=> (pc == '0));
  assert_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && ir[5]) |=> !busy);
endmodule

// File: tb/acq_sequencer_tb.sv
module acq_sequencer_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, run = 0, rd_en = 0;
  logic [3:0] cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic conv_start, conv_short, conv_done;
  logic [2:0] conv_chan;
  logic [12:0] conv_result;
  logic [15:0] rd_data;
  logic [5:0] fill;
  logic overflow, irq, dmarq, busy;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  acq_sequencer u_dut (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .run,
    .conv_start, .conv_chan, .conv_short, .conv_done, .conv_result, .rd_en,
    .rd_data, .fill, .overflow, .irq, .dmarq, .busy);

  // stub converter: 44 cycles full, 20 reduced
  logic [12:0] chv [8];
  logic sb; int scnt; logic [2:0] sch;
  always @(posedge clk) begin
    if (!rst_n) begin sb <= 0; scnt <= 0; sch <= 0; end
    else if (conv_start) begin sb <= 1; sch <= conv_chan; scnt <= conv_short ? 19 : 43; end
    else if (sb) begin if (scnt == 0) sb <= 0; else scnt <= scnt - 1; end
  end
  assign conv_done   = sb && (scnt == 0);
  assign conv_result = chv[sch];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(output logic [15:0] w);
    @(negedge clk); w = rd_data; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic run_until_idle();
    int n = 0;
    @(negedge clk); run = 1;
    while (!busy && n < 10) begin @(negedge clk); n++; end
    while (busy && n < 5000) begin @(negedge clk); n++; end
    run = 0; @(negedge clk);
  endtask

  task automatic flush();
    logic [15:0] w;
    int n = 0;
    while (fill != 0 && n < 40) begin rd(w); n++; end
  endtask

  // {instr, channel value, expected word}
  localparam logic [44:0] VEC [6] = '{
    {16'h0022, 13'h0123, 16'h4123},
    {16'h0025, 13'h1F00, 16'hBF00},
    {16'h002F, 13'h1EFF, 16'hE0FF},
    {16'h0029, 13'h01F0, 16'h3FF0},
    {16'h0020, 13'h1000, 16'h1000},
    {16'h002B, 13'h0100, 16'h7F00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    int n;
    for (int i = 0; i < 8; i++) chv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 fill", fill, 0);
    check("R1 flags", {irq, dmarq, overflow, busy, conv_start}, 0);

    // R4 R5 R2 vector table
    for (int v = 0; v < 6; v++) begin
      chv[VEC[v][31:29]] = VEC[v][28:16];
      wr(0, VEC[v][44:29]);
      run_until_idle();
      check("R4/R5 fill", fill, 1);
      rd(w);
      check("R4/R5 word", w, VEC[v][15:0]);
    end

    // R3 acquisition timing, default 9 then 4
    for (int k = 0; k < 2; k++) begin
      if (k == 1) wr(8, 16'd4);
      wr(0, 16'h0020);
      @(negedge clk); run = 1; n = 0;
      do begin @(posedge clk); n++; @(negedge clk); end while (!conv_start && n < 100);
      check("R3 start delay", n, k == 0 ? 12 : 7);
      @(negedge clk);
      check("R3 start one cycle", conv_start, 0);
      n = 0;
      while (busy && n < 200) begin @(negedge clk); n++; end
      run = 0; flush();
    end
    wr(8, 16'd9);

    // R6 pause after two entries
    chv[4] = 13'h0004; chv[5] = 13'h0005;
    wr(0, 16'h0004); wr(1, 16'h0025);
    run_until_idle();
    check("R6 pause busy", busy, 0);
    check("R6 pause fill", fill, 2);
    rd(w); check("R6 first", w, 16'h8004);
    rd(w); check("R6 second", w, 16'hA005);

    // R6 last-bit wrap, R7 stop via run
    chv[1] = 13'h0011; chv[2] = 13'h0022;
    wr(0, 16'h0001); wr(1, 16'h0042);
    @(negedge clk); run = 1; n = 0;
    while (fill < 5 && n < 2000) begin @(negedge clk); n++; end
    run = 0; n = 0;
    while (busy && n < 200) begin @(negedge clk); n++; end
    check("R7 stopped", busy, 0);
    for (int i = 0; i < 5; i++) begin
      rd(w); check("R6 wrap order", w, (i % 2 == 0) ? 16'h2011 : 16'h4022);
    end
    flush();

    // R8 compare mode, R9 irq clear
    wr(9, 16'hFF9C); wr(10, 16'd100);
    wr(0, 16'h0036);
    chv[6] = 13'd50;
    run_until_idle();
    check("R8 inside no irq", irq, 0);
    check("R8 no store", fill, 0);
    chv[6] = 13'h1F00;
    run_until_idle();
    check("R8 below low irq", irq, 1);
    check("R8 no store low", fill, 0);
    @(negedge clk); rd_en = 1; @(negedge clk); rd_en = 0;
    check("R9 irq cleared", irq, 0);
    chv[6] = 13'd200;
    run_until_idle();
    check("R8 above high irq", irq, 1);
    @(negedge clk); rd_en = 1; @(negedge clk); rd_en = 0;

    // R10 overflow, R11 threshold
    wr(11, 16'd3);
    for (int i = 0; i < 8; i++) wr(4'(i), 16'h0000);
    chv[0] = 13'h0ABC;
    @(negedge clk); run = 1; n = 0;
    while (fill < 32 && n < 5000) begin @(negedge clk); n++; end
    repeat (200) @(negedge clk);
    run = 0; n = 0;
    while (busy && n < 200) begin @(negedge clk); n++; end
    check("R10 full", fill, 32);
    check("R10 overflow", overflow, 1);
    check("R11 dmarq full", dmarq, 1);
    rd(w); check("R10 word", w, 16'h0ABC);
    n = 0;
    while (fill > 3 && n < 40) begin rd(w); n++; end
    check("R11 dmarq at thr", dmarq, 1);
    rd(w);
    check("R11 dmarq below", dmarq, 0);
    check("R10 overflow sticky", overflow, 1);
    wr(12, 16'h0);
    check("R2 R10 overflow cleared", overflow, 0);
    flush();
    check("R10 drained", fill, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule